// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Engine

This block is the slave-side bit layer for a single-wire, open-drain bus. It watches a copy of the bus line and pulls the line low through an enable output. The line first goes through a two-flop synchronizer. It then passes a filter that drops any low pulse shorter than one microsecond tick. A system clock drives the block, and a parameter gives the number of clock cycles per microsecond.

When the master holds the line low for long enough, the block sees a bus reset. It waits for the line to come back high, pauses, and answers with a presence pulse. Any shorter low pulse is a time slot, and its falling edge restarts a microsecond timer. In a write slot the block samples the line at a fixed delay and hands the level upward as a received bit. In a read slot it sends the bit that was latched at the start of the slot: a 0 holds the line low for a fixed time, and a 1 leaves the line alone.

There are two speeds, standard and overdrive. The upper layer asks for overdrive. The length of each reset pulse decides whether overdrive stays in force. All timing in the block follows the current speed.

Top module: `ow_slave_phy`

## Requirements
- R1: After filtering, a low level of at least 480 µs at standard speed, or at least 48 µs in overdrive, counts as a bus reset. When the line returns high, `bus_reset` pulses for one cycle. A shorter low is a slot and gives no `bus_reset` and no presence pulse.
- R2: After a reset, the presence pulse starts 30 µs after the line returns high at standard speed, or 3 µs in overdrive. This falls inside the 15–60 µs and 2–6 µs windows.
- R3: The presence pulse asserts `drive_low` for 120 µs at standard speed, or 16 µs in overdrive. This falls inside the 60–240 µs and 8–24 µs windows.
- R4: A reset pulse longer than 80 µs leaves the block at standard speed (`overdrive` = 0). This includes every reset of 480 µs or more.
- R5: In overdrive, a reset pulse of at most 80 µs keeps `overdrive` = 1. The following presence pulse uses overdrive timing.
- R6: A one-cycle high on `overdrive_req` sets `overdrive` to 1 on the next cycle. The only exception is the cycle in which a reset is being resolved.
- R7: In each slot, the filtered line is sampled once, 30 µs (standard) or 3 µs (overdrive) after the falling edge. The sampled level appears on `rx_bit` with a one-cycle `bit_valid`. A high line gives a received 1.
- R8: `tx_bit` is latched at the falling edge that starts a slot. A latched 0 asserts `drive_low` for 30 µs (standard) or 3 µs (overdrive). A latched 1 never asserts it. Changes to `tx_bit` later in the slot have no effect.
- R9: Low pulses shorter than one tick (`TICK_DIV` clock cycles) are ignored. They give no `bit_valid` and no `drive_low`.
- R10: Out of reset, `drive_low`, `bit_valid`, `bus_reset` and `overdrive` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Raw bus line level (1 = released) |
| drive_low | output | 1 | Open-drain pull-low enable |
| tx_bit | input | 1 | Bit to send in the next read slot |
| overdrive_req | input | 1 | Request from the upper layer to enter overdrive |
| rx_bit | output | 1 | Last received bit |
| bit_valid | output | 1 | One-cycle strobe for `rx_bit` |
| bus_reset | output | 1 | One-cycle strobe at the end of a bus reset |
| overdrive | output | 1 | Current speed (1 = overdrive) |

## Verification
The hardest state to reach from the ports is an overdrive reset whose length is above 48 µs but between the keep and exit limits. Reaching it takes a request into overdrive, then a pulse long enough to count as a reset but too long to keep overdrive. The bench gets there by sending directed reset lengths of 60, 200 and 500 µs after raising `overdrive_req`. It measures the presence delay and width that follow, which shows which speed the block resolved to. Random mixes of read and write slots run at both speeds. A sub-tick glitch and a `tx_bit` change in the middle of a slot cover the filtering and latching rules.

// File: rtl/ow_pkg.sv
package ow_pkg;

    localparam int OW_TIME_W = 16;

    typedef logic [OW_TIME_W-1:0] ow_time_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_RST,
        ST_PD_WAIT,
        ST_PD_LOW,
        ST_PD_END
    } ow_state_e;

    typedef enum logic {
        SPD_STD = 1'b0,
        SPD_OD  = 1'b1
    } ow_speed_e;

    typedef struct packed {
        ow_time_t rst_min;
        ow_time_t pd_wait;
        ow_time_t pd_low;
        ow_time_t sample;
        ow_time_t hold0;
    } ow_timing_t;

    // Overdrive survives a reset only if it was active and the pulse was short.
    function automatic ow_speed_e speed_after_reset(ow_speed_e cur, logic short_pulse);
        return (cur == SPD_OD && short_pulse) ? SPD_OD : SPD_STD;
    endfunction

endpackage

// File: rtl/ow_line_filt.sv
module ow_line_filt #(
    parameter int TICK_DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic line
);
    localparam int CW = $clog2(TICK_DIV + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            line <= 1'b1;
            cnt  <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (s2 == line) begin
                cnt <= '0;
            end else if (cnt == CW'(TICK_DIV - 1)) begin
                line <= s2;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R9: the filtered level only ever takes a value the synchronizer held
    a_r9_filter_follows_sync: assert property (@(posedge clk) disable iff (rst)
        (line != $past(line)) |-> ($past(s2) == line));

endmodule

// File: rtl/ow_us_timer.sv
module ow_us_timer
    import ow_pkg::*;
#(
    parameter int TICK_DIV = 50
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    output ow_time_t elapsed
);
    localparam int PW = $clog2(TICK_DIV + 1);

    logic [PW-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre     <= '0;
            elapsed <= '0;
        end else if (pre == PW'(TICK_DIV - 1)) begin
            pre <= '0;
            if (elapsed != '1) elapsed <= elapsed + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // R2: without a restart the microsecond count never moves backwards
    a_r2_timer_monotonic: assert property (@(posedge clk) disable iff (rst)
        (!restart) |=> (elapsed >= $past(elapsed)));

endmodule

// File: rtl/ow_slave_phy.sv
module ow_slave_phy
    import ow_pkg::*;
#(
    parameter int TICK_DIV       = 50,
    parameter int RST_STD_US     = 480,
    parameter int RST_OD_US      = 48,
    parameter int OD_KEEP_US     = 80,
    parameter int PD_WAIT_STD_US = 30,
    parameter int PD_WAIT_OD_US  = 3,
    parameter int PD_LOW_STD_US  = 120,
    parameter int PD_LOW_OD_US   = 16,
    parameter int SAMPLE_STD_US  = 30,
    parameter int SAMPLE_OD_US   = 3,
    parameter int HOLD0_STD_US   = 30,
    parameter int HOLD0_OD_US    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_in,
    output logic drive_low,
    input  logic tx_bit,
    input  logic overdrive_req,
    output logic rx_bit,
    output logic bit_valid,
    output logic bus_reset,
    output logic overdrive
);
    localparam ow_timing_t T_STD = '{
        rst_min: ow_time_t'(RST_STD_US),
        pd_wait: ow_time_t'(PD_WAIT_STD_US),
        pd_low:  ow_time_t'(PD_LOW_STD_US),
        sample:  ow_time_t'(SAMPLE_STD_US),
        hold0:   ow_time_t'(HOLD0_STD_US)
    };
    localparam ow_timing_t T_OD = '{
        rst_min: ow_time_t'(RST_OD_US),
        pd_wait: ow_time_t'(PD_WAIT_OD_US),
        pd_low:  ow_time_t'(PD_LOW_OD_US),
        sample:  ow_time_t'(SAMPLE_OD_US),
        hold0:   ow_time_t'(HOLD0_OD_US)
    };
    localparam ow_time_t K_KEEP = ow_time_t'(OD_KEEP_US);

    logic       line;
    logic       restart;
    ow_time_t   el;
    ow_timing_t tm;

    ow_state_e  st, st_d;
    ow_speed_e  speed, speed_d;
    logic       tx_lat, tx_lat_d;
    logic       sampled, sampled_d;
    logic       rx_d, drive_d, bv_d, brst_d;

    ow_line_filt #(.TICK_DIV(TICK_DIV)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .raw  (bus_in),
        .line (line)
    );

    ow_us_timer #(.TICK_DIV(TICK_DIV)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .elapsed (el)
    );

    assign tm        = (speed == SPD_OD) ? T_OD : T_STD;
    assign overdrive = (speed == SPD_OD);

    always_comb begin
        st_d      = st;
        speed_d   = speed;
        tx_lat_d  = tx_lat;
        sampled_d = sampled;
        rx_d      = rx_bit;
        drive_d   = 1'b0;
        bv_d      = 1'b0;
        brst_d    = 1'b0;
        restart   = 1'b0;
        if (overdrive_req) speed_d = SPD_OD;
        unique case (st)
            ST_IDLE: begin
                if (!line) begin
                    restart   = 1'b1;
                    tx_lat_d  = tx_bit;
                    sampled_d = 1'b0;
                    st_d      = ST_SLOT;
                end
            end
            ST_SLOT: begin
                drive_d = !tx_lat && (el < tm.hold0);
                if (!sampled && el == tm.sample) begin
                    bv_d      = 1'b1;
                    rx_d      = line;
                    sampled_d = 1'b1;
                end
                if (!line && el >= tm.rst_min) st_d = ST_RST;
                else if (line && sampled)      st_d = ST_IDLE;
            end
            ST_RST: begin
                if (line) begin
                    brst_d  = 1'b1;
                    speed_d = speed_after_reset(speed, el <= K_KEEP);
                    restart = 1'b1;
                    st_d    = ST_PD_WAIT;
                end
            end
            ST_PD_WAIT: begin
                if (el >= tm.pd_wait) begin
                    restart = 1'b1;
                    drive_d = 1'b1;
                    st_d    = ST_PD_LOW;
                end
            end
            ST_PD_LOW: begin
                if (el < tm.pd_low) drive_d = 1'b1;
                else                st_d    = ST_PD_END;
            end
            ST_PD_END: begin
                if (line) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            speed     <= SPD_STD;
            tx_lat    <= 1'b1;
            sampled   <= 1'b0;
            rx_bit    <= 1'b1;
            drive_low <= 1'b0;
            bit_valid <= 1'b0;
            bus_reset <= 1'b0;
        end else begin
            st        <= st_d;
            speed     <= speed_d;
            tx_lat    <= tx_lat_d;
            sampled   <= sampled_d;
            rx_bit    <= rx_d;
            drive_low <= drive_d;
            bit_valid <= bv_d;
            bus_reset <= brst_d;
        end
    end

    // R1: a reset strobe only follows a low that reached the reset threshold
    a_r1_reset_needs_long_low: assert property (@(posedge clk) disable iff (rst)
        bus_reset |-> ($past(el) >= $past(tm.rst_min)));

    // R3: presence drive never outlasts its programmed width
    a_r3_presence_bounded: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PD_LOW && drive_low && $stable(overdrive)) |-> (el <= tm.pd_low));

    // R4: a reset longer than the keep limit ends at standard speed
    a_r4_long_reset_standard: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RST && line && el > K_KEEP) |=> !overdrive);

    // R5: a short reset in overdrive keeps overdrive
    a_r5_short_reset_keeps_od: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RST && line && overdrive && el <= K_KEEP) |=> overdrive);

    // R6: a request outside reset resolution enters overdrive
    a_r6_request_enters_od: assert property (@(posedge clk) disable iff (rst)
        (overdrive_req && !(st == ST_RST && line)) |=> overdrive);

    // R7: the received-bit strobe is a single cycle
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);

    // R8: a latched 1 never pulls the line during the slot
    a_r8_tx1_silent: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SLOT && tx_lat) |=> !drive_low);

endmodule

// File: tb/test_ow_slave_phy.sv
module test_ow_slave_phy;
    localparam int D = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master_low = 1'b0;
    logic tx_bit = 1'b1;
    logic overdrive_req = 1'b0;
    logic bus_in;
    logic drive_low, rx_bit, bit_valid, bus_reset, overdrive;

    int n_tests = 0;
    int n_fail  = 0;
    int bv_cnt  = 0;
    int rst_cnt = 0;
    bit last_rx = 1'b0;

    always #4 clk = ~clk;

    assign bus_in = ~(master_low | drive_low);

    ow_slave_phy #(.TICK_DIV(D)) i_ow_slave_phy (
        .clk           (clk),
        .rst           (rst),
        .bus_in        (bus_in),
        .drive_low     (drive_low),
        .tx_bit        (tx_bit),
        .overdrive_req (overdrive_req),
        .rx_bit        (rx_bit),
        .bit_valid     (bit_valid),
        .bus_reset     (bus_reset),
        .overdrive     (overdrive)
    );

    always @(negedge clk) begin
        if (bit_valid) begin
            bv_cnt  = bv_cnt + 1;
            last_rx = rx_bit;
        end
        if (bus_reset) rst_cnt = rst_cnt + 1;
    end

    function automatic int exp_hold(bit b, bit od);
        return b ? 0 : (od ? 3 : 30) * D;
    endfunction
    function automatic int pd_wait_lo(bit od); return (od ? 2 : 15) * D;  endfunction
    function automatic int pd_wait_hi(bit od); return (od ? 6 : 60) * D;  endfunction
    function automatic int pd_len_lo(bit od);  return (od ? 8 : 60) * D;  endfunction
    function automatic int pd_len_hi(bit od);  return (od ? 24 : 240) * D; endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(int low_us, bit exp_rst, bit exp_od, string od_req);
        int c0 = rst_cnt;
        int dly = 0;
        int len = 0;
        bit seen = 1'b0;
        master_low = 1'b1;
        wait_cyc(low_us * D);
        master_low = 1'b0;
        for (int i = 0; i < 400 * D && !seen; i++) begin
            @(negedge clk);
            if (drive_low) seen = 1'b1;
            else dly++;
        end
        if (seen) begin
            len = 1;
            @(negedge clk);
            while (drive_low) begin
                len++;
                @(negedge clk);
            end
        end
        wait_cyc(20 * D);
        check(rst_cnt == c0 + (exp_rst ? 1 : 0), "R1", "reset strobes", rst_cnt - c0, exp_rst ? 1 : 0);
        check(seen == exp_rst, "R1", "presence seen", seen, exp_rst);
        if (exp_rst) begin
            check(dly >= pd_wait_lo(exp_od) && dly <= pd_wait_hi(exp_od), "R2", "presence delay cycles",
                  dly, exp_od ? 3 * D : 30 * D);
            check(len >= pd_len_lo(exp_od) && len <= pd_len_hi(exp_od), "R3", "presence width cycles",
                  len, exp_od ? 16 * D : 120 * D);
        end
        check(overdrive == exp_od, od_req, "speed after low pulse", overdrive, exp_od);
    endtask

    task automatic write_slot(bit b, bit od);
        int lowc  = od ? (b ? 2 * D : 8 * D) : (b ? 6 * D : 60 * D);
        int slotc = od ? 12 * D : 75 * D;
        int c0 = bv_cnt;
        tx_bit = 1'b1;
        master_low = 1'b1;
        wait_cyc(lowc);
        master_low = 1'b0;
        wait_cyc(slotc - lowc);
        check(bv_cnt == c0 + 1, "R7", "bit strobes per write slot", bv_cnt - c0, 1);
        check(last_rx == b, "R7", "received bit", last_rx, b);
    endtask

    task automatic read_slot(bit b, bit od, bit flip);
        int slotc = od ? 12 * D : 75 * D;
        int cnt = 0;
        int expc = exp_hold(b, od);
        tx_bit = b;
        master_low = 1'b1;
        for (int i = 0; i < slotc; i++) begin
            @(negedge clk);
            if (i == D + 1) master_low = 1'b0;
            if (flip && i == 3 * D) tx_bit = ~b;
            if (drive_low) cnt++;
        end
        tx_bit = 1'b1;
        if (b)
            check(cnt == 0, "R8", "drive cycles for a 1", cnt, 0);
        else
            check(cnt >= expc - D && cnt <= expc + D, "R8", "drive cycles for a 0", cnt, expc);
    endtask

    task automatic request_od();
        overdrive_req = 1'b1;
        @(negedge clk);
        overdrive_req = 1'b0;
        @(negedge clk);
        check(overdrive == 1'b1, "R6", "overdrive after request", overdrive, 1);
    endtask

    task automatic random_slots(int n, bit od);
        for (int k = 0; k < n; k++) begin
            bit isw;
            bit b;
            isw = 1'($urandom_range(0, 1));
            b   = 1'($urandom_range(0, 1));
            if (isw) write_slot(b, od);
            else     read_slot(b, od, 1'b0);
        end
    endtask

    initial begin
        int unsigned seed_v;
        int c0;
        int drv;
        seed_v = $urandom(32'd20240);
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        // R10: idle outputs after reset
        check(drive_low == 1'b0, "R10", "drive_low", drive_low, 0);
        check(bit_valid == 1'b0, "R10", "bit_valid", bit_valid, 0);
        check(bus_reset == 1'b0, "R10", "bus_reset", bus_reset, 0);
        check(overdrive == 1'b0, "R10", "overdrive", overdrive, 0);
        wait_cyc(10 * D);

        // R1 R2 R3 R4: standard reset and a long low that is not a reset
        do_reset(500, 1'b1, 1'b0, "R4");
        do_reset(300, 1'b0, 1'b0, "R1");

        // R9: sub-tick glitch
        c0 = bv_cnt;
        drv = 0;
        master_low = 1'b1;
        wait_cyc(D - 2);
        master_low = 1'b0;
        for (int i = 0; i < 100 * D; i++) begin
            @(negedge clk);
            if (drive_low) drv++;
        end
        check(bv_cnt == c0, "R9", "strobes after glitch", bv_cnt - c0, 0);
        check(drv == 0, "R9", "drive after glitch", drv, 0);

        // R7 R8: directed standard slots, including a mid-slot tx change
        write_slot(1'b1, 1'b0);
        write_slot(1'b0, 1'b0);
        read_slot(1'b0, 1'b0, 1'b0);
        read_slot(1'b1, 1'b0, 1'b0);
        read_slot(1'b0, 1'b0, 1'b1);
        read_slot(1'b1, 1'b0, 1'b1);
        random_slots(16, 1'b0);

        // R6 R5: overdrive entry, slots and a short reset that keeps it
        request_od();
        write_slot(1'b1, 1'b1);
        write_slot(1'b0, 1'b1);
        read_slot(1'b0, 1'b1, 1'b0);
        random_slots(16, 1'b1);
        do_reset(60, 1'b1, 1'b1, "R5");
        do_reset(30, 1'b0, 1'b1, "R5");

        // R4: mid-length overdrive reset and a long one both drop to standard
        do_reset(200, 1'b1, 1'b0, "R4");
        request_od();
        do_reset(500, 1'b1, 1'b0, "R4");
        write_slot(1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule